// File: doc/BRIEF.md
# Cartridge Bank Controller with Real-Time Clock

This block sits on the cartridge side of a CPU bus with a 16-bit address space. CPU writes that land in the read-only program area are not stored; they are decoded as commands that enable the external RAM window, pick a program bank, pick a RAM bank or a clock register, and take a clock snapshot. The block drives the upper address bits for up to 128 program banks of 16 KB and four RAM banks of 8 KB. It also drives the RAM chip-select and write strobe. It supplies the read data for the external RAM window whenever the RAM itself is not the source.

The clock counts seconds, minutes, hours and a 9-bit day number from a one-cycle `tick_1hz_i` pulse. Software does not read the running counters. It reads a snapshot that a two-write command freezes. A write to a clock register changes the running counter and the snapshot at once.

The block decodes only the top three address bits. Bits [15:13] split the command area into four 8 KB ranges, and the value `101` marks the external RAM window.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write of exactly 0x0A to 0x0000–0x1FFF enables the RAM/clock window. A write of any other value to that range disables it.
- R2: A write to 0x2000–0x3FFF stores bits [6:0] of the data as the program bank, and a stored 0 becomes 1. `rom_bank_o` shows the bank for addresses 0x4000–0x7FFF and 0 for every other address.
- R3: A write to 0x4000–0x5FFF stores bits [3:0] of the data as the window selector. Values 0–3 map RAM bank `ram_bank_o` = value[1:0]. In that case, while the window is enabled, an access to 0xA000–0xBFFF raises `ram_cs_o`, a write also raises `ram_we_o`, and read data comes from `ram_rdata_i`.
- R4: While the window is disabled, or while the selector holds 4–7 or 0x0D–0x0F, reads of 0xA000–0xBFFF return 0xFF. In the same cases `ram_cs_o` and `ram_we_o` stay low and writes change no clock register.
- R5: Selector values 0x08 to 0x0C map one clock register into the window: 0x08 is seconds, 0x09 is minutes, 0x0A is hours and 0x0B is the low 8 bits of the day. 0x0C reads {carry, halt, 5'b0, day[8]}. Reads return the snapshot.
- R6: Each cycle with `tick_1hz_i` high advances the running clock by one second. Seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, hours wrap 23→0 into the day, and the day counts 0–511.
- R7: When the day rolls over from 511 to 0, the carry flag (bit 7 of register 0x0C) sets. It stays set until software writes it to 0.
- R8: While the halt flag (bit 6 of register 0x0C) is set, ticks do not change the running clock.
- R9: A write of 0x00 to 0x6000–0x7FFF, followed by a write of 0x01 as the next write to that range, copies the running clock into the snapshot. No other sequence of writes to that range copies the clock.
- R10: A write into the window while a clock register is selected and the window is enabled loads that field into both the running clock and the snapshot.
- R11: After reset the window is disabled, the program bank is 1, the selector is 0 and every clock field and flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle pulse, one second of clock time |
| cpu_addr_hi_i | input | 3 | CPU address bits [15:13] |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| ram_rdata_i | input | 8 | Read data from the external RAM |
| cpu_rdata_o | output | 8 | Read data for the RAM window |
| rom_bank_o | output | 7 | Program bank address bits |
| ram_bank_o | output | 2 | RAM bank address bits |
| ram_cs_o | output | 1 | External RAM chip-select |
| ram_we_o | output | 1 | External RAM write enable |

## Verification
Every byte value is written to the enable range, and the bench checks that only 0x0A opens the window. This separates a full-byte compare from a compare on the low nibble alone. Every byte value is also written to the bank register, so the bench can tell masking of bit 7 apart from the zero-to-one remap. All sixteen selector values are tried, which separates RAM banks, clock registers and unmapped codes.

The clock is loaded at points just before the second, minute, hour, day-bit-8 and day-overflow boundaries, then ticked. The result is compared with the elapsed seconds added arithmetically to the start time. The latch command is sent alone, broken by a foreign value and repeated, so the bench can tell a true back-to-back detector from one that only watches for the final 0x01.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int SEC_MAX = 59;
  localparam int MIN_MAX = 59;
  localparam int HR_MAX  = 23;
  localparam int DAY_W   = 9;

  localparam logic [2:0] FLD_SEC = 3'd0;
  localparam logic [2:0] FLD_MIN = 3'd1;
  localparam logic [2:0] FLD_HR  = 3'd2;
  localparam logic [2:0] FLD_DL  = 3'd3;
  localparam logic [2:0] FLD_DH  = 3'd4;

  localparam logic [7:0] EN_KEY  = 8'h0A;

  typedef enum logic [1:0] {
    RGN_ENABLE = 2'd0,
    RGN_ROMSEL = 2'd1,
    RGN_WINSEL = 2'd2,
    RGN_LATCH  = 2'd3
  } cmd_rgn_e;

  typedef struct packed {
    logic             carry;
    logic             halt;
    logic [DAY_W-1:0] day;
    logic [4:0]       hr;
    logic [5:0]       mn;
    logic [5:0]       sc;
  } rtc_t;
endpackage

// File: rtl/cbc_cmd_dec.sv
module cbc_cmd_dec
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int SEL_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [2:0]            addr_hi_i,
  input  logic [7:0]            wdata_i,
  output logic                  ram_en_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  latch_o
);
  logic     cmd_wr;
  cmd_rgn_e rgn;
  logic     zero_seen_q;

  assign cmd_wr = wr_i && !addr_hi_i[2];
  assign rgn    = cmd_rgn_e'(addr_hi_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_o    <= 1'b0;
      rom_bank_o  <= ROM_BANK_W'(1);
      sel_o       <= '0;
      zero_seen_q <= 1'b0;
    end else if (cmd_wr) begin
      case (rgn)
        RGN_ENABLE: ram_en_o <= (wdata_i == EN_KEY);
        RGN_ROMSEL: rom_bank_o <= (wdata_i[ROM_BANK_W-1:0] == '0) ?
                                  ROM_BANK_W'(1) : wdata_i[ROM_BANK_W-1:0];
        RGN_WINSEL: sel_o <= wdata_i[SEL_W-1:0];
        RGN_LATCH:  zero_seen_q <= (wdata_i == 8'h00);
        default: ;
      endcase
    end
  end

  // latch only when the previous write to this range was 0x00
  assign latch_o = cmd_wr && (rgn == RGN_LATCH) && (wdata_i == 8'h01) && zero_seen_q;

  assert_bank_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && rgn == RGN_ROMSEL) |=> (rom_bank_o != '0));
endmodule

// File: rtl/cbc_rtc.sv
module cbc_rtc
  import cbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       latch_i,
  input  logic       wr_i,
  input  logic [2:0] fld_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  rtc_t live_q, snap_q, adv;
  logic sc_wrap, mn_wrap, hr_wrap, day_wrap;

  function automatic rtc_t put_fld(rtc_t r, logic [2:0] f, logic [7:0] d);
    rtc_t o = r;
    case (f)
      FLD_SEC: o.sc = d[5:0];
      FLD_MIN: o.mn = d[5:0];
      FLD_HR:  o.hr = d[4:0];
      FLD_DL:  o.day[7:0] = d;
      FLD_DH: begin
        o.day[DAY_W-1] = d[0];
        o.halt         = d[6];
        o.carry        = d[7];
      end
      default: ;
    endcase
    return o;
  endfunction

  assign sc_wrap  = (live_q.sc == 6'(SEC_MAX));
  assign mn_wrap  = (live_q.mn == 6'(MIN_MAX));
  assign hr_wrap  = (live_q.hr == 5'(HR_MAX));
  assign day_wrap = (live_q.day == {DAY_W{1'b1}});

  always_comb begin
    adv    = live_q;
    adv.sc = sc_wrap ? '0 : live_q.sc + 6'd1;
    if (sc_wrap) adv.mn = mn_wrap ? '0 : live_q.mn + 6'd1;
    if (sc_wrap && mn_wrap) adv.hr = hr_wrap ? '0 : live_q.hr + 5'd1;
    if (sc_wrap && mn_wrap && hr_wrap) begin
      adv.day = live_q.day + DAY_W'(1);
      if (day_wrap) adv.carry = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      snap_q <= '0;
    end else if (wr_i) begin
      live_q <= put_fld(live_q, fld_i, wdata_i);
      snap_q <= put_fld(snap_q, fld_i, wdata_i);
    end else begin
      if (tick_i && !live_q.halt) live_q <= adv;
      if (latch_i) snap_q <= live_q;
    end
  end

  always_comb begin
    case (fld_i)
      FLD_SEC: rdata_o = {2'b00, snap_q.sc};
      FLD_MIN: rdata_o = {2'b00, snap_q.mn};
      FLD_HR:  rdata_o = {3'b000, snap_q.hr};
      FLD_DL:  rdata_o = snap_q.day[7:0];
      FLD_DH:  rdata_o = {snap_q.carry, snap_q.halt, 5'b0, snap_q.day[DAY_W-1]};
      default: rdata_o = 8'hFF;
    endcase
  end

  assert_sec_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && !live_q.halt && live_q.sc == 6'(SEC_MAX)) |=> (live_q.sc == '0));
  assert_carry_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q.carry && !(wr_i && fld_i == FLD_DH)) |=> live_q.carry);
  assert_halt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q.halt && !wr_i) |=> $stable(live_q));
  assert_latch_copy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !wr_i) |=> (snap_q == $past(live_q)));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_1hz_i,
  input  logic [2:0]            cpu_addr_hi_i,
  input  logic                  cpu_wr_i,
  input  logic                  cpu_rd_i,
  input  logic [7:0]            cpu_wdata_i,
  input  logic [7:0]            ram_rdata_i,
  output logic [7:0]            cpu_rdata_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [RAM_BANK_W-1:0] ram_bank_o,
  output logic                  ram_cs_o,
  output logic                  ram_we_o
);
  localparam int SEL_W = 4;

  logic                  ram_en;
  logic [ROM_BANK_W-1:0] bank_q;
  logic [SEL_W-1:0]      sel;
  logic                  latch;
  logic                  in_win, win_open, sel_ram, sel_rtc, rtc_wr;
  logic [7:0]            rtc_rdata;

  cbc_cmd_dec #(.ROM_BANK_W(ROM_BANK_W), .SEL_W(SEL_W)) i_cmd_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cpu_wr_i),
    .addr_hi_i  (cpu_addr_hi_i),
    .wdata_i    (cpu_wdata_i),
    .ram_en_o   (ram_en),
    .rom_bank_o (bank_q),
    .sel_o      (sel),
    .latch_o    (latch)
  );

  assign in_win   = (cpu_addr_hi_i == 3'b101);
  assign win_open = ram_en && in_win;
  assign sel_ram  = (sel[SEL_W-1:RAM_BANK_W] == '0);
  assign sel_rtc  = sel[3] && (sel[2:0] <= FLD_DH);
  assign rtc_wr   = win_open && sel_rtc && cpu_wr_i;

  cbc_rtc i_rtc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_1hz_i),
    .latch_i (latch),
    .wr_i    (rtc_wr),
    .fld_i   (sel[2:0]),
    .wdata_i (cpu_wdata_i),
    .rdata_o (rtc_rdata)
  );

  assign rom_bank_o = (cpu_addr_hi_i[2:1] == 2'b01) ? bank_q : '0;
  assign ram_bank_o = sel[RAM_BANK_W-1:0];
  assign ram_cs_o   = win_open && sel_ram && (cpu_rd_i || cpu_wr_i);
  assign ram_we_o   = win_open && sel_ram && cpu_wr_i;

  always_comb begin
    if (!win_open)    cpu_rdata_o = 8'hFF;
    else if (sel_ram) cpu_rdata_o = ram_rdata_i;
    else if (sel_rtc) cpu_rdata_o = rtc_rdata;
    else              cpu_rdata_o = 8'hFF;
  end

  assert_cs_closed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_en |-> (!ram_cs_o && !ram_we_o));
  assert_upper_bank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_hi_i[2:1] == 2'b01) |-> (rom_bank_o != '0));
  assert_we_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_cs_o);
endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [15:0] addr = 16'h0000;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, ram_rd = 0;
  logic [7:0] rdata;
  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       cs, we;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .cpu_addr_hi_i(addr[15:13]),
    .cpu_wr_i(wr_en), .cpu_rd_i(rd_en), .cpu_wdata_i(wdata), .ram_rdata_i(ram_rd),
    .cpu_rdata_o(rdata), .rom_bank_o(rom_bank), .ram_bank_o(ram_bank),
    .ram_cs_o(cs), .ram_we_o(we)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata; c = cs;
    rd_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
    end
    @(negedge clk); tick = 0;
  endtask

  task automatic do_latch();
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
  endtask

  task automatic set_rtc(input int s, input int m, input int h, input int d, input logic [7:0] flags);
    wr(16'h4000, 8'h08); wr(16'hA000, 8'(s));
    wr(16'h4000, 8'h09); wr(16'hA000, 8'(m));
    wr(16'h4000, 8'h0A); wr(16'hA000, 8'(h));
    wr(16'h4000, 8'h0B); wr(16'hA000, 8'(d));
    wr(16'h4000, 8'h0C); wr(16'hA000, flags | 8'((d >> 8) & 1));
  endtask

  task automatic rd_rtc(input logic [7:0] sel, output logic [7:0] v);
    logic c;
    wr(16'h4000, sel); rd(16'hA000, v, c);
  endtask

  task automatic run_count(input int s, input int m, input int h, input int d, input int n);
    int total, ed;
    logic [7:0] v;
    set_rtc(s, m, h, d, 8'h00);
    ticks(n);
    do_latch();
    total = s + 60*m + 3600*h + 86400*d + n;
    ed = total / 86400;
    rd_rtc(8'h08, v); chk("R6 sec", v, total % 60);
    rd_rtc(8'h09, v); chk("R6 min", v, (total / 60) % 60);
    rd_rtc(8'h0A, v); chk("R6 hour", v, (total / 3600) % 24);
    rd_rtc(8'h0B, v); chk("R6 day low", v, (ed % 512) & 255);
    rd_rtc(8'h0C, v); chk("R7 day high/carry", v, ((ed >= 512) ? 128 : 0) | (((ed % 512) >> 8) & 1));
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic c;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    @(negedge clk); addr = 16'h4000; #1 chk("R11 bank", rom_bank, 1);
    rd(16'hA000, v, c); chk("R11 disabled data", v, 8'hFF); chk("R11 disabled cs", c, 0);
    wr(16'h0000, 8'h0A);
    rd(16'hA000, v, c); chk("R11 sel 0 cs", c, 1); chk("R11 ram bank", ram_bank, 0);
    for (int f = 8; f <= 12; f++) begin
      rd_rtc(8'(f), v); chk("R11 clock zero", v, 0);
    end

    // R2 bank sweep
    for (int b = 0; b < 256; b++) begin
      wr(16'h2000 + 16'(b), 8'(b));
      @(negedge clk); addr = 16'h4000 + 16'(b * 64); #1
      chk("R2 upper bank", rom_bank, ((b & 127) == 0) ? 1 : (b & 127));
    end
    @(negedge clk); addr = 16'h3FFF; #1 chk("R2 lower area", rom_bank, 0);
    @(negedge clk); addr = 16'hA000; #1 chk("R2 outside rom", rom_bank, 0);

    // R1 enable sweep
    wr(16'h4000, 8'h00);
    for (int e = 0; e < 256; e++) begin
      wr(16'h1F00, 8'(e));
      rd(16'hA000, v, c); chk("R1 enable key", c, (e == 10) ? 1 : 0);
    end

    // R3/R4/R5 selector sweep
    wr(16'h0000, 8'h0A);
    set_rtc(1, 2, 3, 4, 8'h00);
    for (int s = 0; s < 16; s++) begin
      wr(16'h4000, 8'(s));
      ram_rd = 8'h5A ^ 8'(s);
      rd(16'hA000 + 16'(s * 16), v, c);
      if (s < 4) begin
        chk("R3 cs", c, 1); chk("R3 bank", ram_bank, s); chk("R3 data", v, 8'h5A ^ s);
      end else if (s >= 8 && s <= 12) begin
        chk("R5 no ram cs", c, 0);
        chk("R5 field", v, (s == 12) ? 0 : (s - 7));
      end else begin
        chk("R4 unmapped cs", c, 0); chk("R4 unmapped data", v, 8'hFF);
      end
    end
    wr(16'h4000, 8'h02);
    @(negedge clk); addr = 16'hB123; wdata = 8'h77; wr_en = 1;
    #1 chk("R3 we", we, 1); chk("R3 write cs", cs, 1); chk("R3 write bank", ram_bank, 2);
    @(negedge clk); wr_en = 0;

    // R6/R7 counting at boundaries
    run_count(0, 0, 0, 0, 130);
    run_count(59, 58, 23, 10, 70);
    run_count(30, 59, 22, 255, 3700);
    run_count(58, 59, 23, 511, 5);
    // R7 carry sticky then cleared
    ticks(20); do_latch();
    rd_rtc(8'h0C, v); chk("R7 carry sticky", v[7], 1);
    wr(16'hA000, 8'h00); do_latch();
    rd_rtc(8'h0C, v); chk("R7 carry cleared", v[7], 0);

    // R8 halt
    set_rtc(10, 20, 3, 7, 8'h40);
    ticks(50); do_latch();
    rd_rtc(8'h08, v); chk("R8 halted sec", v, 10);
    rd_rtc(8'h0C, v); chk("R8 halt flag", v, 8'h40);
    wr(16'hA000, 8'h00); ticks(5); do_latch();
    rd_rtc(8'h08, v); chk("R8 resumed sec", v, 15);

    // R9 latch sequences, R10 write reaches snapshot
    set_rtc(0, 0, 0, 0, 8'h00);
    rd_rtc(8'h08, v); chk("R10 write visible", v, 0);
    ticks(5);
    wr(16'h6000, 8'h01);
    rd_rtc(8'h08, v); chk("R9 lone 01", v, 0);
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h02); wr(16'h6000, 8'h01);
    rd_rtc(8'h08, v); chk("R9 broken seq", v, 0);
    wr(16'h6000, 8'h00); wr(16'h6000, 8'h00); wr(16'h6000, 8'h01);
    rd_rtc(8'h08, v); chk("R9 latch", v, 5);
    ticks(4);
    rd_rtc(8'h08, v); chk("R9 snapshot frozen", v, 5);
    wr(16'hA000, 8'd33);
    rd_rtc(8'h08, v); chk("R10 write sec", v, 33);

    // R4 writes ignored while disabled
    wr(16'h0000, 8'h00);
    @(negedge clk); addr = 16'hA000; wdata = 8'd44; wr_en = 1;
    #1 chk("R4 disabled we", we, 0);
    @(negedge clk); wr_en = 0;
    rd(16'hA000, v, c); chk("R4 disabled read", v, 8'hFF);
    wr(16'h0000, 8'h0A);
    rd_rtc(8'h08, v); chk("R4 write ignored", v, 33);
    do_latch();
    rd_rtc(8'h08, v); chk("R4 live unchanged", v, 33);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule